// File: doc/BRIEF.md
# Width-Switchable Processor Register File

This block keeps the architectural registers of an 8/16-bit processor core and performs the register-only operations of its instruction set. It holds a 16-bit accumulator whose low byte (A) and high byte (B) can be used on their own. It also holds two index registers, a direct-page base, a stack pointer, a data bank byte, a status byte and a hidden emulation flag. Decode, arithmetic and memory traffic are handled elsewhere. The surrounding core issues one command per cycle on a one-hot strobe word, with an operand byte and, for loads, a 16-bit data word.

Two status bits set the operand widths. Bit 5 sets the accumulator width and bit 4 sets the index width; a 1 selects 8 bits and a 0 selects 16 bits. These width rules are applied on every register write. Narrowing the index registers destroys their high bytes for good, while the accumulator high byte is always kept. The emulation flag can only be changed by exchanging it with the carry (status bit 0). While the flag is set, both width bits are held at 1. Every command takes effect at the clock edge on which it is presented, and the new state is visible on the outputs right after that edge.

Top module: `widthRegFile`

## Requirements
- R1: After reset the emulation flag is 1, the status byte is 0x34, the accumulator, X, Y, direct page and data bank are 0, and the stack pointer is 0x01FF.
- R2: The clear-bits command (strobe bit 0) clears each status bit that is 1 in the operand and leaves all others unchanged.
- R3: The set-bits command (strobe bit 1) sets each status bit that is 1 in the operand and leaves all others unchanged.
- R4: While the emulation flag is 1, status bits 5 and 4 stay 1, whether a clear-bits command or a status load tries to clear them.
- R5: The exchange command (strobe bit 2) swaps status bit 0 with the emulation flag in one step. When the flag becomes 1, status bits 5 and 4 become 1.
- R6: Whenever status bit 4 becomes 1, by set-bits, by status load or by entering emulation, the high bytes of X and Y become 0. They stay 0 after bit 4 is cleared again.
- R7: Changing status bit 5 in either direction leaves both bytes of the accumulator unchanged.
- R8: The swap command (strobe bit 3) exchanges the accumulator's low and high bytes.
- R9: The transfer command (strobe bit 4) takes its source code from operand bits 6:4 and its destination code from bits 2:0 (0=accumulator, 1=X, 2=Y, 3=direct page, 4=stack pointer). When the destination is 16 bits wide, all 16 source bits are copied. Direct page and stack pointer are always 16 bits wide.
- R10: A transfer into an 8-bit destination copies only the source low byte. An 8-bit accumulator keeps its high byte, and an 8-bit index register gets a zero high byte.
- R11: The load command (strobe bit 5) writes the data word into the register chosen by operand bits 2:0 (0=accumulator, 1=X, 2=Y, 3=direct page, 4=stack pointer, 5=data bank from the low byte, 6=status from the low byte), following the same width rules as a transfer.
- R12: A strobe word without exactly one bit set, a transfer with equal source and destination or a code above 4, and a load with code 7 all leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStrobe | input | 6 | One-hot command: bit 0 clear bits, 1 set bits, 2 exchange, 3 swap, 4 transfer, 5 load |
| cmdOperand | input | 8 | Bit mask, transfer codes or load target |
| wrData | input | 16 | Data word for the load command |
| accC | output | 16 | Accumulator (high byte B, low byte A) |
| idxX | output | 16 | X index register |
| idxY | output | 16 | Y index register |
| dirPage | output | 16 | Direct-page base |
| stackPtr | output | 16 | Stack pointer |
| dataBank | output | 8 | Data bank byte |
| statusP | output | 8 | Status byte |
| emuFlag | output | 1 | Emulation flag |

## Verification
The assertions assume only that reset is held for at least one clock edge before any command. The strobe and operand inputs may take any value. Word-level assertions cover the invariants that hold in any case: an 8-bit index has a zero high byte, and emulation forces the width bits. The bench drives each command as a single-cycle pulse between idle cycles, so every result can be traced to one command. It also applies malformed strobe words and invalid codes on purpose, which checks that the control filters them out.

// File: rtl/widthRegFilePkg.sv
package widthRegFilePkg;
  localparam int NUM_CMD  = 6;
  localparam int CMD_CLR  = 0;
  localparam int CMD_SET  = 1;
  localparam int CMD_EXCH = 2;
  localparam int CMD_SWAP = 3;
  localparam int CMD_XFER = 4;
  localparam int CMD_LOAD = 5;

  localparam logic [2:0] SEL_ACC = 3'd0;
  localparam logic [2:0] SEL_X   = 3'd1;
  localparam logic [2:0] SEL_Y   = 3'd2;
  localparam logic [2:0] SEL_DP  = 3'd3;
  localparam logic [2:0] SEL_SP  = 3'd4;
  localparam logic [2:0] SEL_DB  = 3'd5;
  localparam logic [2:0] SEL_ST  = 3'd6;

  localparam int BIT_CARRY = 0;
  localparam int BIT_IDX   = 4;
  localparam int BIT_ACC   = 5;

  typedef struct packed {
    logic       doClear;
    logic       doSet;
    logic       doExch;
    logic       doSwap;
    logic       doXfer;
    logic       doLoad;
    logic [2:0] srcSel;
    logic [2:0] dstSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/widthRegFileCtrl.sv
module widthRegFileCtrl
  import widthRegFilePkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CMD-1:0] cmdStrobe,
  input  logic [7:0]         cmdOperand,
  output ctrlStrobes_t       strobes
);
  logic       isOneHot;
  logic [2:0] srcCode;
  logic [2:0] dstCode;
  logic       xferOk;
  logic       loadOk;

  assign isOneHot = ($countones(cmdStrobe) == 1);
  assign srcCode  = cmdOperand[6:4];
  assign dstCode  = cmdOperand[2:0];
  assign xferOk   = (srcCode <= SEL_SP) && (dstCode <= SEL_SP) && (srcCode != dstCode);
  assign loadOk   = (dstCode != 3'd7);

  always_comb begin
    strobes         = '0;
    strobes.srcSel  = srcCode;
    strobes.dstSel  = dstCode;
    if (isOneHot) begin
      strobes.doClear = cmdStrobe[CMD_CLR];
      strobes.doSet   = cmdStrobe[CMD_SET];
      strobes.doExch  = cmdStrobe[CMD_EXCH];
      strobes.doSwap  = cmdStrobe[CMD_SWAP];
      strobes.doXfer  = cmdStrobe[CMD_XFER] && xferOk;
      strobes.doLoad  = cmdStrobe[CMD_LOAD] && loadOk;
    end
  end

  AST_MALFORMED_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(cmdStrobe) != 1) |->
      !(strobes.doClear || strobes.doSet || strobes.doExch ||
        strobes.doSwap || strobes.doXfer || strobes.doLoad)); // R12

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.doClear, strobes.doSet, strobes.doExch,
                strobes.doSwap, strobes.doXfer, strobes.doLoad}) <= 1); // R12
endmodule

// File: rtl/widthRegFileDp.sv
module widthRegFileDp
  import widthRegFilePkg::*;
#(
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] SP_RESET = 16'h01FF,
  parameter logic [7:0] ST_RESET = 8'h34
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [7:0]        maskByte,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] accC,
  output logic [WORD_W-1:0] idxX,
  output logic [WORD_W-1:0] idxY,
  output logic [WORD_W-1:0] dirPage,
  output logic [WORD_W-1:0] stackPtr,
  output logic [7:0]        dataBank,
  output logic [7:0]        statusP,
  output logic              emuFlag
);
  localparam int BYTE_W = WORD_W / 2;

  logic [WORD_W-1:0] accQ, xQ, yQ, dpQ, spQ;
  logic [WORD_W-1:0] accD, xD, yD, dpD, spD;
  logic [7:0]        dbQ, dbD, stQ, stD;
  logic              emuQ, emuD;
  logic [WORD_W-1:0] srcVal;
  logic [WORD_W-1:0] accWide, idxWide;
  logic              accNarrow, idxNarrow;
  logic              writeEn;
  logic [2:0]        writeSel;
  logic [WORD_W-1:0] writeVal;

  assign accNarrow = stQ[BIT_ACC];
  assign idxNarrow = stQ[BIT_IDX];

  always_comb begin
    unique case (strobes.srcSel)
      SEL_ACC: srcVal = accQ;
      SEL_X:   srcVal = xQ;
      SEL_Y:   srcVal = yQ;
      SEL_DP:  srcVal = dpQ;
      default: srcVal = spQ;
    endcase
  end

  assign writeEn  = strobes.doXfer || strobes.doLoad;
  assign writeSel = strobes.dstSel;
  assign writeVal = strobes.doLoad ? wrData : srcVal;

  assign accWide = accNarrow ? {accQ[WORD_W-1:BYTE_W], writeVal[BYTE_W-1:0]} : writeVal;
  assign idxWide = idxNarrow ? {{BYTE_W{1'b0}}, writeVal[BYTE_W-1:0]} : writeVal;

  always_comb begin
    stD  = stQ;
    emuD = emuQ;
    if (strobes.doClear) stD = stQ & ~maskByte;
    if (strobes.doSet)   stD = stQ | maskByte;
    if (strobes.doExch) begin
      emuD           = stQ[BIT_CARRY];
      stD[BIT_CARRY] = emuQ;
    end
    if (strobes.doLoad && writeSel == SEL_ST) stD = wrData[7:0];
    if (emuD) begin
      stD[BIT_ACC] = 1'b1;
      stD[BIT_IDX] = 1'b1;
    end
  end

  always_comb begin
    accD = accQ;
    xD   = xQ;
    yD   = yQ;
    dpD  = dpQ;
    spD  = spQ;
    dbD  = dbQ;
    if (strobes.doSwap) accD = {accQ[BYTE_W-1:0], accQ[WORD_W-1:BYTE_W]};
    if (writeEn) begin
      unique case (writeSel)
        SEL_ACC: accD = accWide;
        SEL_X:   xD   = idxWide;
        SEL_Y:   yD   = idxWide;
        SEL_DP:  dpD  = writeVal;
        SEL_SP:  spD  = writeVal;
        SEL_DB:  dbD  = writeVal[7:0];
        default: ;
      endcase
    end
    if (stD[BIT_IDX]) begin
      xD[WORD_W-1:BYTE_W] = '0;
      yD[WORD_W-1:BYTE_W] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
      xQ   <= '0;
      yQ   <= '0;
      dpQ  <= '0;
      spQ  <= SP_RESET;
      dbQ  <= '0;
      stQ  <= ST_RESET;
      emuQ <= 1'b1;
    end else begin
      accQ <= accD;
      xQ   <= xD;
      yQ   <= yD;
      dpQ  <= dpD;
      spQ  <= spD;
      dbQ  <= dbD;
      stQ  <= stD;
      emuQ <= emuD;
    end
  end

  assign accC     = accQ;
  assign idxX     = xQ;
  assign idxY     = yQ;
  assign dirPage  = dpQ;
  assign stackPtr = spQ;
  assign dataBank = dbQ;
  assign statusP  = stQ;
  assign emuFlag  = emuQ;

  AST_EMU_WIDTH_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    emuQ |-> (stQ[BIT_ACC] && stQ[BIT_IDX])); // R4

  AST_NARROW_IDX_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    stQ[BIT_IDX] |-> (xQ[WORD_W-1:BYTE_W] == '0 && yQ[WORD_W-1:BYTE_W] == '0)); // R6

  AST_EXCH_SWAPS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doExch |=> (emuQ == $past(stQ[BIT_CARRY]) && stQ[BIT_CARRY] == $past(emuQ))); // R5

  AST_FLAGOP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doClear || strobes.doSet) |=> $stable(accQ)); // R7

  AST_SWAP_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doSwap |=> (accQ == {$past(accQ[BYTE_W-1:0]), $past(accQ[WORD_W-1:BYTE_W])})); // R8

  AST_NARROW_ACC_KEEPS_B: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && writeSel == SEL_ACC && accNarrow) |=>
      (accQ[WORD_W-1:BYTE_W] == $past(accQ[WORD_W-1:BYTE_W]))); // R10
endmodule

// File: rtl/widthRegFile.sv
module widthRegFile
  import widthRegFilePkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CMD-1:0] cmdStrobe,
  input  logic [7:0]         cmdOperand,
  input  logic [WORD_W-1:0]  wrData,
  output logic [WORD_W-1:0]  accC,
  output logic [WORD_W-1:0]  idxX,
  output logic [WORD_W-1:0]  idxY,
  output logic [WORD_W-1:0]  dirPage,
  output logic [WORD_W-1:0]  stackPtr,
  output logic [7:0]         dataBank,
  output logic [7:0]         statusP,
  output logic               emuFlag
);
  ctrlStrobes_t strobes;

  widthRegFileCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdStrobe  (cmdStrobe),
    .cmdOperand (cmdOperand),
    .strobes    (strobes)
  );

  widthRegFileDp #(.WORD_W(WORD_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .maskByte (cmdOperand),
    .wrData   (wrData),
    .accC     (accC),
    .idxX     (idxX),
    .idxY     (idxY),
    .dirPage  (dirPage),
    .stackPtr (stackPtr),
    .dataBank (dataBank),
    .statusP  (statusP),
    .emuFlag  (emuFlag)
  );
endmodule

// File: tb/sim_widthRegFile.sv
module sim_widthRegFile;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  cmdStrobe = '0;
  logic [7:0]  cmdOperand = '0;
  logic [15:0] wrData = '0;
  logic [15:0] accC, idxX, idxY, dirPage, stackPtr;
  logic [7:0]  dataBank, statusP;
  logic        emuFlag;

  int checks = 0;
  int fails = 0;

  logic [15:0] eC, eX, eY, eD, eS;
  logic [7:0]  eB, eP;
  logic        eE;

  widthRegFile u0 (
    .clk(clk), .rstN(rstN), .cmdStrobe(cmdStrobe), .cmdOperand(cmdOperand),
    .wrData(wrData), .accC(accC), .idxX(idxX), .idxY(idxY), .dirPage(dirPage),
    .stackPtr(stackPtr), .dataBank(dataBank), .statusP(statusP), .emuFlag(emuFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk(tag, "acc",   accC, eC);
    chk(tag, "x",     idxX, eX);
    chk(tag, "y",     idxY, eY);
    chk(tag, "dp",    dirPage, eD);
    chk(tag, "sp",    stackPtr, eS);
    chk(tag, "bank",  {8'h00, dataBank}, {8'h00, eB});
    chk(tag, "stat",  {8'h00, statusP}, {8'h00, eP});
    chk(tag, "emu",   {15'h0, emuFlag}, {15'h0, eE});
  endtask

  task automatic issue(logic [5:0] s, logic [7:0] op, logic [15:0] d);
    @(negedge clk);
    cmdStrobe  = s;
    cmdOperand = op;
    wrData     = d;
    @(negedge clk);
    cmdStrobe  = '0;
    cmdOperand = '0;
    wrData     = '0;
  endtask

  task automatic tReset;
    eC = 0; eX = 0; eY = 0; eD = 0; eS = 16'h01FF; eB = 0; eP = 8'h34; eE = 1;
    checkAll("R1");
  endtask

  task automatic tFlagsAndExchange;
    issue(6'b000001, 8'h34, 0); eP = 8'h30;            checkAll("R2_R4");
    issue(6'b000100, 8'h00, 0); eE = 0; eP = 8'h31;    checkAll("R5");
    issue(6'b000001, 8'h30, 0); eP = 8'h01;            checkAll("R2");
    issue(6'b000010, 8'h80, 0); eP = 8'h81;            checkAll("R3");
    issue(6'b000001, 8'h80, 0); eP = 8'h01;            checkAll("R2");
  endtask

  task automatic tLoads;
    issue(6'b100000, 8'h00, 16'h1234); eC = 16'h1234;
    issue(6'b100000, 8'h01, 16'hABCD); eX = 16'hABCD;
    issue(6'b100000, 8'h02, 16'h5678); eY = 16'h5678;
    issue(6'b100000, 8'h03, 16'h0300); eD = 16'h0300;
    issue(6'b100000, 8'h04, 16'h1FF0); eS = 16'h1FF0;
    issue(6'b100000, 8'h05, 16'h997E); eB = 8'h7E;
    checkAll("R11");
  endtask

  task automatic tAccWidth;
    issue(6'b000010, 8'h20, 0); eP = 8'h21;            checkAll("R7");
    issue(6'b100000, 8'h00, 16'hFFEE); eC = 16'h12EE;  checkAll("R11");
    issue(6'b000001, 8'h20, 0); eP = 8'h01;            checkAll("R7");
    issue(6'b001000, 8'h00, 0); eC = 16'hEE12;         checkAll("R8");
  endtask

  task automatic tWideXfer;
    issue(6'b010000, 8'h03, 0); eD = 16'hEE12;         checkAll("R9");
    issue(6'b010000, 8'h04, 0); eS = 16'hEE12;         checkAll("R9");
    issue(6'b010000, 8'h12, 0); eY = 16'hABCD;         checkAll("R9");
    issue(6'b100000, 8'h03, 16'h0300); eD = 16'h0300;
    issue(6'b010000, 8'h30, 0); eC = 16'h0300;         checkAll("R9");
    issue(6'b010000, 8'h40, 0); eC = 16'hEE12;         checkAll("R9");
    issue(6'b100000, 8'h00, 16'h0399); eC = 16'h0399;
  endtask

  task automatic tIdxWidth;
    issue(6'b000010, 8'h10, 0); eP = 8'h11; eX = 16'h00CD; eY = 16'h00CD; checkAll("R6");
    issue(6'b000001, 8'h10, 0); eP = 8'h01;            checkAll("R6");
    issue(6'b000010, 8'h10, 0); eP = 8'h11;
    issue(6'b010000, 8'h01, 0); eX = 16'h0099;         checkAll("R10");
    issue(6'b100000, 8'h01, 16'h7788); eX = 16'h0088;  checkAll("R11");
    issue(6'b000010, 8'h20, 0); eP = 8'h31;
    issue(6'b010000, 8'h10, 0); eC = 16'h0388;         checkAll("R10");
  endtask

  task automatic tIgnored;
    issue(6'b000011, 8'hFF, 16'hFFFF); checkAll("R12");
    issue(6'b110000, 8'h01, 16'hFFFF); checkAll("R12");
    issue(6'b010000, 8'h11, 0);        checkAll("R12");
    issue(6'b010000, 8'h07, 0);        checkAll("R12");
    issue(6'b010000, 8'h50, 0);        checkAll("R12");
    issue(6'b100000, 8'h07, 16'hFFFF); checkAll("R12");
  endtask

  task automatic tEnterEmulation;
    issue(6'b000001, 8'h30, 0); eP = 8'h01;
    issue(6'b100000, 8'h01, 16'h1234); eX = 16'h1234; checkAll("R11");
    issue(6'b000100, 8'h00, 0); eE = 1; eP = 8'h30; eX = 16'h0034; checkAll("R5_R6");
    issue(6'b100000, 8'h06, 16'h0000); eP = 8'h30;    checkAll("R4");
    issue(6'b000001, 8'h30, 0);                       checkAll("R4");
    issue(6'b000100, 8'h00, 0); eE = 0; eP = 8'h31;
    issue(6'b000001, 8'h10, 0); eP = 8'h21;
    issue(6'b100000, 8'h01, 16'h4455); eX = 16'h4455;
    issue(6'b100000, 8'h06, 16'h00D3); eP = 8'hD3; eX = 16'h0055; eY = 16'h00CD;
    checkAll("R6_R11");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        tReset();
        tFlagsAndExchange();
        tLoads();
        tAccWidth();
        tWideXfer();
        tIdxWidth();
        tIgnored();
        tEnterEmulation();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule